// File: doc/BRIEF.md
# Button Matrix Select Register

This block is the CPU-visible input register for a handheld controller with eight buttons wired as two groups of four. Software writes a two-bit select field to choose which group appears on the low four bits of the register. Reading the register returns fixed ones in the top two bits, the stored select field in bits 5:4, and the chosen button lines in bits 3:0.

The button lines are active low: a 0 on a `btn_i` bit means that button is held. The first group is `btn_i[3:0]` and the second is `btn_i[7:4]`. When both groups are selected, the two nibbles are ANDed, so a held button in either group reads as 0. The low nibble is recomputed every clock from the current select field and button state. Each time any low-nibble line goes from 1 to 0, the block sends a one-cycle interrupt request. The system interrupt controller uses this pulse to set joypad flag bit 4.

Top module: `joy_matrix_reg`

## Requirements
- R1: While reset is held, and just after it is released, with all buttons released (`btn_i` = 8'hFF) the register reads 8'hCF and `irq_o` is 0. The select field resets to 2'b00.
- R2: A write stores only write-data bits 5:4 as the select field. It takes effect on the clock edge that samples `wr_en_i`. Bits 7:6 of the read value are always 1, and no other write-data bit has any effect.
- R3: With the select field at 2'b10, read bits 3:0 equal `btn_i[3:0]`.
- R4: With the select field at 2'b01, read bits 3:0 equal `btn_i[7:4]`.
- R5: With the select field at 2'b00, read bits 3:0 equal `btn_i[3:0] & btn_i[7:4]`.
- R6: With the select field at 2'b11, read bits 3:0 equal 4'hF, whatever the button state.
- R7: When `wr_en_i` is low, the select field keeps its value.
- R8: If any low-nibble bit sampled at a clock edge is 0 where it was 1 at the previous edge, `irq_o` is 1 for the cycle after that edge. The cause can be a button change or a select write.
- R9: `irq_o` stays 0 when the low nibble only rises or holds steady. A held button therefore gives a pulse of exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Write data; only bits 5:4 are stored |
| rd_data_o | output | 8 | Register read value |
| btn_i | input | 8 | Button state, 0 = pressed; bits 3:0 first group, 7:4 second group |
| irq_o | output | 1 | One-cycle joypad interrupt request |

## Verification
A wrong stored select field shows up in `rd_data_o[5:4]` in the cycle right after the faulty write. It also misroutes the low nibble, and that error lasts until the next write. A wrong previous-nibble register shows up as a missing, extra or stretched `irq_o` pulse one cycle after the edge in question. The bench drives every select value against all 256 button patterns, then runs a mixed pseudo-random stream of writes and button changes. This exposes either kind of fault within one cycle.

// File: rtl/joy_pkg.sv
package joy_pkg;
  typedef enum logic [1:0] {
    SEL_BOTH = 2'b00,
    SEL_HI   = 2'b01,
    SEL_LO   = 2'b10,
    SEL_NONE = 2'b11
  } joy_sel_e;

  localparam int unsigned SEL_LSB = 4;
  localparam int unsigned SEL_W   = 2;
endpackage

// File: rtl/joy_sel_reg.sv
module joy_sel_reg
  import joy_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  output joy_sel_e      sel_o
);
  joy_sel_e sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sel_q <= SEL_BOTH;
    else if (wr_en_i) sel_q <= joy_sel_e'(wr_data_i[SEL_LSB +: SEL_W]);
  end

  assign sel_o = sel_q;
endmodule

// File: rtl/joy_nib_mux.sv
module joy_nib_mux
  import joy_pkg::*;
#(
  parameter int unsigned GW = 4
) (
  input  joy_sel_e        sel_i,
  input  logic [2*GW-1:0] btn_i,
  output logic [GW-1:0]   nib_o
);
  logic [GW-1:0] grp_lo, grp_hi;

  assign grp_lo = btn_i[GW-1:0];
  assign grp_hi = btn_i[2*GW-1:GW];

  always_comb begin
    unique case (sel_i)
      SEL_LO:   nib_o = grp_lo;
      SEL_HI:   nib_o = grp_hi;
      SEL_BOTH: nib_o = grp_lo & grp_hi; // pressed (0) in either group wins
      default:  nib_o = '1;
    endcase
  end
endmodule

// File: rtl/joy_fall_det.sv
module joy_fall_det #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] nib_i,
  output logic         irq_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] fell;
  logic         irq_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign fell[i] = prev_q[i] & ~nib_i[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '1;
      irq_q  <= 1'b0;
    end else begin
      prev_q <= nib_i;
      irq_q  <= |fell;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/joy_matrix_reg.sv
module joy_matrix_reg
  import joy_pkg::*;
#(
  parameter int unsigned BTN_W = 8,
  parameter int unsigned DW    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [DW-1:0]    wr_data_i,
  output logic [DW-1:0]    rd_data_o,
  input  logic [BTN_W-1:0] btn_i,
  output logic             irq_o
);
  localparam int unsigned GW = BTN_W / 2;

  joy_sel_e      sel;
  logic [GW-1:0] nib;

  joy_sel_reg #(.DW(DW)) u_sel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .sel_o     (sel)
  );

  joy_nib_mux #(.GW(GW)) u_mux (
    .sel_i (sel),
    .btn_i (btn_i),
    .nib_o (nib)
  );

  joy_fall_det #(.W(GW)) u_fall (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .nib_i  (nib),
    .irq_o  (irq_o)
  );

  // unused upper bits read as ones
  always_comb begin
    rd_data_o                    = '1;
    rd_data_o[SEL_LSB +: SEL_W]  = sel;
    rd_data_o[GW-1:0]            = nib;
  end
endmodule

// File: rtl/joy_matrix_reg_chk.sv
module joy_matrix_reg_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [7:0] wr_data_i,
  input logic [7:0] rd_data_o,
  input logic [7:0] btn_i,
  input logic       irq_o
);
  assert_sel_store_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o[5:4] == $past(wr_data_i[5:4]));

  assert_sel_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(rd_data_o[5:4]));

  assert_grp_lo_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[5:4] == 2'b10 |-> rd_data_o[3:0] == btn_i[3:0]);

  assert_grp_hi_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[5:4] == 2'b01 |-> rd_data_o[3:0] == btn_i[7:4]);

  assert_grp_both_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[5:4] == 2'b00 |-> rd_data_o[3:0] == (btn_i[3:0] & btn_i[7:4]));

  assert_grp_none_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[5:4] == 2'b11 |-> rd_data_o[3:0] == 4'hF);

  assert_fall_irq_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(rd_data_o[3:0]) & ~rd_data_o[3:0])) |=> irq_o);

  assert_irq_cause_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(rd_data_o[3:0]) != 4'hF);
endmodule

bind joy_matrix_reg joy_matrix_reg_chk u_chk (.*);

// File: tb/joy_matrix_reg_bench.sv
`timescale 1ns/1ps
module joy_matrix_reg_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] btn = 8'hFF;
  logic [7:0] rd_data;
  logic       irq;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  logic [1:0]  m_sel = 2'b00;
  logic [3:0]  m_prev = 4'hF;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  joy_matrix_reg u_joy_matrix_reg (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .rd_data_o (rd_data),
    .btn_i     (btn),
    .irq_o     (irq)
  );

  function automatic logic [3:0] nib_f(input logic [1:0] s, input logic [7:0] b);
    case (s)
      2'b10:   return b[3:0];
      2'b01:   return b[7:4];
      2'b00:   return b[3:0] & b[7:4];
      default: return 4'hF;
    endcase
  endfunction

  function automatic string sel_tag(input logic [1:0] s);
    case (s)
      2'b10:   return "R3";
      2'b01:   return "R4";
      2'b00:   return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  // drive at negedge, model at posedge, sample at next negedge
  task automatic step(input logic we, input logic [7:0] d, input logic [7:0] b);
    logic [3:0] cur;
    logic       exp_irq;
    wr_en = we; wr_data = d; btn = b;
    @(posedge clk);
    cur     = nib_f(m_sel, b);
    exp_irq = |(m_prev & ~cur);
    m_prev  = cur;
    if (we) m_sel = d[5:4];
    @(negedge clk);
    chk8({sel_tag(m_sel), "/R2/R7 read"}, rd_data, {2'b11, m_sel, nib_f(m_sel, b)});
    chk8("R8/R9 irq", {7'd0, irq}, {7'd0, exp_irq});
    wr_en = 1'b0;
  endtask

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk8("R1 reset read", rd_data, 8'hCF);
    chk8("R1 reset irq", {7'd0, irq}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk8("R1 post-reset read", rd_data, 8'hCF);
    chk8("R1 post-reset irq", {7'd0, irq}, 8'h00);

    // exhaustive sweep: every select against every button pattern
    for (int s = 0; s < 4; s++) begin
      for (int b = 0; b < 256; b++) begin
        step(b == 0, {2'b00, s[1:0], 4'b0000}, b[7:0]);
      end
    end

    // R2: only bits 5:4 matter
    step(1'b1, 8'h3F, 8'h00);
    step(1'b1, 8'hC0, 8'hA5);
    step(1'b1, 8'hEF, 8'h5A);
    step(1'b1, 8'h1F, 8'h3C);

    // R8/R9 directed: single press held, release, write-caused fall
    step(1'b1, 8'h30, 8'hFF);
    step(1'b1, 8'h20, 8'hFF);
    step(1'b0, 8'h00, 8'hFE);
    step(1'b0, 8'h00, 8'hFE);
    step(1'b0, 8'h00, 8'hFE);
    step(1'b0, 8'h00, 8'hFF);
    step(1'b0, 8'h00, 8'h7F);
    step(1'b1, 8'h10, 8'h7F);
    step(1'b0, 8'h00, 8'h7F);
    step(1'b1, 8'h30, 8'h7F);
    step(1'b1, 8'h00, 8'hEF);

    // mixed pseudo-random stream
    lfsr = 16'hACE1;
    for (int k = 0; k < 600; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] & lfsr[3], {lfsr[15:8]}, lfsr[11:4] | {lfsr[2], 1'b0, lfsr[1], 5'b0});
    end

    done = 1'b1;
  end

  initial begin
    int unsigned cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule